// File: doc/BRIEF.md
# Bidirectional Three-State Step Sequencer

The block is a synchronous sequencer with three states. It keeps its state in two positive-edge JK storage cells and moves to a new state on every rising clock edge. A direction input selects which way the state walks. With the direction low it walks zero, one, two and back to zero. With the direction high it walks zero, two, one and back to zero. Both K inputs are tied high during normal stepping, so each next state comes from the J gating alone.

A Mealy flag marks the non-zero states of the low-direction walk. It is formed from the direction input and the present state, so it follows a change of direction between clock edges without waiting for a clock edge. The two-bit code 3 is never entered during normal stepping. If it does appear, the block leaves it on the next edge whatever the direction. A synchronous preset path loads any code through the J/K inputs. This path lets a test place the block in the unused code.

Top module: `tri_step_seq`

## Requirements
- R1: With `rst_n` low at a rising edge, the state becomes 0 (`state_hi`=0, `state_lo`=0). Reset overrides both preset and stepping.
- R2: With `dir_sel`=0, the state code {state_hi,state_lo} steps 00 → 01 → 10 → 00, one step per rising edge.
- R3: With `dir_sel`=1, the state code steps 00 → 10 → 01 → 00, one step per rising edge.
- R4: `fwd_flag` equals 1 exactly when `dir_sel`=0 and the state code is not 00. It follows `dir_sel` combinationally within the same cycle.
- R5: From the unused code 11, the state becomes 00 on the next rising edge, for either value of `dir_sel`.
- R6: With `rst_n` high and `preset_en`=1 at a rising edge, the state takes the value of `preset_code` (bit 1 goes to `state_hi`) instead of stepping.
- R7: The JK storage cell, on a rising edge with its reset released, treats {J,K} as follows: 00 holds, 01 clears, 10 sets and 11 inverts. With its reset low, the cell clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_sel | input | 1 | Walk direction: 0 gives 0-1-2, 1 gives 0-2-1 |
| preset_en | input | 1 | Load `preset_code` on the next edge |
| preset_code | input | 2 | Code to load, bit 1 is the high state bit |
| state_hi | output | 1 | High bit of the state code |
| state_lo | output | 1 | Low bit of the state code |
| fwd_flag | output | 1 | Mealy flag for the non-zero states of the direction-0 walk |

## Verification
The case that is hardest to reach is the unused code 11. Stepping in either direction never produces it, so the only way in is the preset path. The stimulus loads 11 and then clocks once with each direction value, which checks that the block falls back to 00. The random phase also changes `dir_sel` in the middle of a cycle and checks the flag before and after the change, to show that the flag responds without a clock edge while the state uses only the value present at the edge.

// File: rtl/tri_seq_pkg.sv
// Shared definitions for the three-state step sequencer.
// Assumes a two-bit state code with bit 1 as the high bit.
package tri_seq_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_ZERO = 2'b00,
        ST_ONE  = 2'b01,
        ST_TWO  = 2'b10,
        ST_VOID = 2'b11
    } step_state_t;
endpackage

// File: rtl/jk_cell.sv
// Positive-edge JK storage cell with synchronous active-low clear.
// Assumes j and k settle before the rising edge; RST_VAL is the cleared value.
module jk_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic j,
    input  logic k,
    output logic q
);
    // State update: hold, clear, set or invert chosen by {j,k}.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RST_VAL;
        end else begin
            case ({j, k})
                2'b00:   q <= q;
                2'b01:   q <= 1'b0;
                2'b10:   q <= 1'b1;
                default: q <= ~q;
            endcase
        end
    end

    AST_JK_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
        (j && k) |=> (q != $past(q)));                                   // R7
    AST_JK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!j && !k) |=> $stable(q));                                      // R7
    AST_JK_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (q == RST_VAL));                                      // R7
endmodule

// File: rtl/step_gating.sv
// Excitation logic for the two JK cells of the sequencer.
// When stepping, both K inputs are held at 1 and each J is a two-input parity term.
// When preset_en is set, J/K are driven so that each cell loads its preset bit.
module step_gating
    import tri_seq_pkg::*;
(
    input  logic               dir_sel,
    input  logic [STATE_W-1:0] cur,
    input  logic               preset_en,
    input  logic [STATE_W-1:0] preset_code,
    output logic [STATE_W-1:0] j_out,
    output logic [STATE_W-1:0] k_out
);
    logic [STATE_W-1:0] j_step;

    // Stepping terms: low cell J = XNOR(dir, high bit); high cell J = XOR(dir, low bit).
    always_comb begin
        j_step[0] = ~(dir_sel ^ cur[1]);
        j_step[1] = dir_sel ^ cur[0];
    end

    for (genvar i = 0; i < STATE_W; i++) begin : g_steer
        // Per-cell steering: a preset becomes set (10) or clear (01), stepping uses K=1.
        always_comb begin
            if (preset_en) begin
                j_out[i] = preset_code[i];
                k_out[i] = ~preset_code[i];
            end else begin
                j_out[i] = j_step[i];
                k_out[i] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mealy_flag.sv
// Mealy output decode: flags non-zero states while the direction is 0.
// Assumes nothing about timing; purely combinational from direction and state.
module mealy_flag
    import tri_seq_pkg::*;
(
    input  logic               dir_sel,
    input  logic [STATE_W-1:0] cur,
    output logic               flag
);
    // Flag decode from live direction and present state.
    always_comb begin
        flag = ~dir_sel & (|cur);
    end
endmodule

// File: rtl/tri_step_seq.sv
// Top of the bidirectional three-state sequencer built from JK cells.
// Assumes synchronous inputs; the unused code 11 falls back to 00 on the next edge.
module tri_step_seq
    import tri_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dir_sel,
    input  logic               preset_en,
    input  logic [STATE_W-1:0] preset_code,
    output logic               state_hi,
    output logic               state_lo,
    output logic               fwd_flag
);
    logic [STATE_W-1:0] q_bus;
    logic [STATE_W-1:0] j_bus;
    logic [STATE_W-1:0] k_bus;

    step_gating u_gating (
        .dir_sel     (dir_sel),
        .cur         (q_bus),
        .preset_en   (preset_en),
        .preset_code (preset_code),
        .j_out       (j_bus),
        .k_out       (k_bus)
    );

    for (genvar i = 0; i < STATE_W; i++) begin : g_cell
        jk_cell #(.RST_VAL(1'b0)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .j     (j_bus[i]),
            .k     (k_bus[i]),
            .q     (q_bus[i])
        );
    end

    mealy_flag u_flag (
        .dir_sel (dir_sel),
        .cur     (q_bus),
        .flag    (fwd_flag)
    );

    // Output mapping: bit 1 of the state code is the high bit.
    always_comb begin
        state_hi = q_bus[1];
        state_lo = q_bus[0];
    end

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> ({state_hi, state_lo} == ST_ZERO));                   // R1
    AST_FWD_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_en && !dir_sel && q_bus != ST_VOID) |=>
        (q_bus == (($past(q_bus) == ST_ZERO) ? ST_ONE :
                   ($past(q_bus) == ST_ONE)  ? ST_TWO : ST_ZERO)));      // R2
    AST_REV_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_en && dir_sel && q_bus != ST_VOID) |=>
        (q_bus == (($past(q_bus) == ST_ZERO) ? ST_TWO :
                   ($past(q_bus) == ST_TWO)  ? ST_ONE : ST_ZERO)));      // R3
    AST_FLAG_DIR_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        dir_sel |-> !fwd_flag);                                          // R4
    AST_VOID_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_en && q_bus == ST_VOID) |=> (q_bus == ST_ZERO));        // R5
    AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        preset_en |=> (q_bus == $past(preset_code)));                    // R6
endmodule

// File: tb/tri_step_seq_tb.sv
`timescale 1ns/1ps
module tri_step_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_sel = 1'b0;
    logic       preset_en = 1'b0;
    logic [1:0] preset_code = 2'b00;
    logic       state_hi, state_lo, fwd_flag;
    logic       cj = 1'b0, ck = 1'b0, cq;

    int checks = 0;
    int errors = 0;
    logic [1:0] exp_st = 2'b00;
    logic       exp_cq = 1'b0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    tri_step_seq u_dut (
        .clk(clk), .rst_n(rst_n), .dir_sel(dir_sel), .preset_en(preset_en),
        .preset_code(preset_code), .state_hi(state_hi), .state_lo(state_lo),
        .fwd_flag(fwd_flag)
    );

    jk_cell #(.RST_VAL(1'b0)) u_cell (
        .clk(clk), .rst_n(rst_n), .j(cj), .k(ck), .q(cq)
    );

    function automatic logic [1:0] ref_next(input logic d, input logic [1:0] s);
        if (s == 2'b11) return 2'b00;
        if (!d) return (s == 2'b00) ? 2'b01 : (s == 2'b01) ? 2'b10 : 2'b00;
        return (s == 2'b00) ? 2'b10 : (s == 2'b10) ? 2'b01 : 2'b00;
    endfunction

    function automatic logic ref_flag(input logic d, input logic [1:0] s);
        return !d && (s != 2'b00);
    endfunction

    function automatic logic ref_cell(input logic j, input logic k, input logic q);
        case ({j, k})
            2'b00:   return q;
            2'b01:   return 1'b0;
            2'b10:   return 1'b1;
            default: return ~q;
        endcase
    endfunction

    task automatic check_val(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock cycle: optional mid-cycle direction glitch, then the final inputs.
    task automatic cycle(input logic d, input logic r, input logic pe, input logic [1:0] pc,
                         input logic j, input logic k, input logic glitch);
        string tag;
        @(negedge clk);
        if (glitch) begin
            dir_sel = ~d;
            #1 check_val("R4", {1'b0, fwd_flag}, {1'b0, ref_flag(~d, exp_st)});
        end
        dir_sel = d; rst_n = r; preset_en = pe; preset_code = pc; cj = j; ck = k;
        #1 check_val("R4", {1'b0, fwd_flag}, {1'b0, ref_flag(d, exp_st)});
        @(posedge clk);
        if (!r)                 tag = "R1";
        else if (pe)            tag = "R6";
        else if (exp_st == 2'b11) tag = "R5";
        else if (!d)            tag = "R2";
        else                    tag = "R3";
        exp_cq = r ? ref_cell(j, k, exp_cq) : 1'b0;
        exp_st = !r ? 2'b00 : pe ? pc : ref_next(d, exp_st);
        #2;
        check_val(tag, {state_hi, state_lo}, exp_st);
        check_val("R7", {1'b0, cq}, {1'b0, exp_cq});
    endtask

    initial begin
        void'($urandom(32'h00C0FFEE));
        // R1: reset state, also with preset requested
        cycle(1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        // R2: direction 0 walk, R7 set then hold
        cycle(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0);
        // R3: direction 1 walk, R7 clear
        for (int i = 0; i < 4; i++) cycle(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1);
        // R5: unused code via preset, recover with each direction
        cycle(1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0);
        // R6: preset overrides stepping
        cycle(1'b0, 1'b1, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0);
        // Random phase
        for (int i = 0; i < 400; i++) begin
            logic d, r, pe, g;
            logic [1:0] pc, jk;
            d  = 1'($urandom);
            r  = ($urandom % 25) != 0;
            pe = ($urandom % 8) == 0;
            pc = 2'($urandom);
            jk = 2'($urandom);
            g  = 1'($urandom);
            cycle(d, r, pe, pc, jk[1], jk[0], g);
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(64'd8 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule